// File: doc/BRIEF.md
# Core Step Sequencer with Cache-Miss Stall Tracking

This block is the sequencing controller of a simple in-order core that retires at most one instruction per step. It decides each cycle whether the core steps. It issues a word-aligned instruction fetch, hands either the freshly fetched word or a word parked during an instruction-cache miss to the execute datapath, and moves the PC / next-PC pair forward. The cache, decode and execute logic sit outside. The block only sees their hit/miss answers, a fault flag, a memory-reference flag and a miss-completion pulse.

The instruction cache answers in the fetch cycle itself. `ic_hit` high means the word is on `ic_rdata`. `ic_hit` low is a miss, and the word returns later on `ic_rdata` together with `miss_done`. The fetch strobe therefore has no ready signal and there is no back-pressure: a miss stands in for "not ready", and the sequencer stops issuing until completion. A data-cache miss is reported on the execute cycle through `ex_mem` and `dc_hit`. Activate, suspend and switch-out are plain one-cycle command pulses.

A miss that is already fetched resumes from a dedicated state without fetching again. Once the core is switched out of service it stays parked until reset and silently drops late completions.

Top module: `corestep_top`

## Requirements
- R1: After reset the state code is Idle (0), `pc` equals RESET_PC, `npc` equals RESET_PC+4, both stall counters are zero and `fetch_valid`, `exec_valid`, `trap_req`, `r0_clr`, `err` are low.
- R2: `act_req` in Idle moves the state to Running (1) on the next cycle. The first step then happens `act_dly` cycles after entering Running, and no step happens before it.
- R3: `susp_req` in Running returns the state to Idle (0) on the next cycle, and no step happens in the cycle it is applied.
- R4: Every fetch presents `fetch_addr` equal to `pc` with bits [1:0] cleared. `fetch_phys` equals `pc[0]` when FULL_SYS is 1 and is 0 otherwise.
- R5: A fetch with `ic_hit` low executes nothing that cycle and moves to IcacheMissStall (2). No fetch is issued while stalled.
- R6: `miss_done` in IcacheMissStall moves to IcacheMissComplete (3). The step in that state issues no fetch, presents the word carried by `ic_rdata` at completion on `exec_inst`, and then returns to Running.
- R7: An executed step with `ex_mem` high and `dc_hit` low still advances the PC and moves to DcacheMissStall (4). `miss_done` there returns to Running, which steps on the very next cycle.
- R8: `swout_req` moves any state to SwitchedOut (5), where no step occurs. A `miss_done` there raises no error, changes no state and leaves the stall counters unchanged.
- R9: An executed step with `ex_fault` low sets `pc` to `npc` and adds 4 to `npc`. With `ex_fault` high, `trap_req` is high in that cycle and the pair holds.
- R10: `r0_clr` is high exactly in the cycles in which a step is taken, whether the step is a fetch or an execute of a held word.
- R11: `err` is high for one cycle after an `act_req` outside Idle, a `susp_req` outside Running, or a `miss_done` in Idle, Running or IcacheMissComplete. The command itself causes no state change.
- R12: Each stall counter adds one for every cycle spent in its stall state and saturates at all ones. `stats_clr` clears both counters synchronously and wins over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stats_clr | input | 1 | Clear both stall counters |
| act_req | input | 1 | Activate command pulse |
| act_dly | input | DLY_W | Cycles from entering Running to first step |
| susp_req | input | 1 | Suspend command pulse |
| swout_req | input | 1 | Switch-out command pulse |
| miss_done | input | 1 | Outstanding cache miss has completed |
| ic_hit | input | 1 | Instruction cache hit for the current fetch |
| ic_rdata | input | INST_W | Instruction word (on hit or with miss_done) |
| ex_mem | input | 1 | Executing instruction is a load or store |
| dc_hit | input | 1 | Data cache hit for that load or store |
| ex_fault | input | 1 | Executing instruction faulted |
| core_state | output | 3 | State code (0..5 as in the requirements) |
| fetch_valid | output | 1 | Fetch strobe |
| fetch_addr | output | PC_W | Word-aligned fetch address |
| fetch_phys | output | 1 | Fetch is a physical access |
| exec_valid | output | 1 | Execute strobe |
| exec_inst | output | INST_W | Instruction word to execute |
| trap_req | output | 1 | Trap request on faulted step |
| r0_clr | output | 1 | Force integer register 0 to zero this step |
| err | output | 1 | Illegal command or completion seen last cycle |
| ic_stall_cyc | output | CNT_W | Instruction-miss stall cycles |
| dc_stall_cyc | output | CNT_W | Data-miss stall cycles |
| pc | output | PC_W | Current PC |
| npc | output | PC_W | Next PC |

## Verification
The bench sweeps every activate delay of a 3-bit configuration. A design that counts the delay from the command cycle rather than from entry into Running would step one cycle early. It sweeps instruction-miss lengths far enough to push a 4-bit counter into saturation, where a wrapping counter would read back a small value. It also checks that the resumed step presents the parked word rather than whatever `ic_rdata` shows at that moment, which is how a design that refetches would be caught. Late completions after switch-out, fault steps that must hold the PC, and every illegal command in the wrong state are each driven, so that a spurious error or a moved state shows at the ports.

// File: rtl/corestep_pkg.sv
package corestep_pkg;
  typedef enum logic [2:0] {
    CS_IDLE   = 3'd0,
    CS_RUN    = 3'd1,
    CS_IMISS  = 3'd2,
    CS_IREADY = 3'd3,
    CS_DMISS  = 3'd4,
    CS_PARKED = 3'd5
  } core_state_e;
endpackage

// File: rtl/corestep_fsm.sv
module corestep_fsm
  import corestep_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_req,
  input  logic [DLY_W-1:0] act_dly,
  input  logic             susp_req,
  input  logic             swout_req,
  input  logic             miss_done,
  input  logic             ic_hit,
  input  logic             ex_mem,
  input  logic             dc_hit,
  input  logic             ex_fault,
  output core_state_e      state,
  output logic             fetch_valid,
  output logic             exec_valid,
  output logic             exec_held,
  output logic             hold_load,
  output logic             advance,
  output logic             trap_req,
  output logic             step,
  output logic             err
);
  core_state_e      state_q, state_d;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic             err_q;
  logic             run_step, dmiss;
  logic             act_bad, susp_bad, done_bad;

  // Step gating: a switch-out or suspend pre-empts the step of that cycle.
  assign run_step    = (state_q == CS_RUN) && (wait_q == '0) && !swout_req && !susp_req;
  assign exec_held   = (state_q == CS_IREADY) && !swout_req;
  assign fetch_valid = run_step;
  assign exec_valid  = (run_step && ic_hit) || exec_held;
  assign trap_req    = exec_valid && ex_fault;
  assign advance     = exec_valid && !ex_fault;
  assign dmiss       = advance && ex_mem && !dc_hit;
  assign step        = run_step || exec_held;
  assign hold_load   = (state_q == CS_IMISS) && miss_done && !swout_req;

  assign act_bad  = act_req && (state_q != CS_IDLE);
  assign susp_bad = susp_req && (state_q != CS_RUN);
  assign done_bad = miss_done &&
                    ((state_q == CS_IDLE) || (state_q == CS_RUN) || (state_q == CS_IREADY));

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    if (swout_req) begin
      state_d = CS_PARKED;
    end else begin
      unique case (state_q)
        CS_IDLE: if (act_req) begin
          state_d = CS_RUN;
          wait_d  = act_dly;
        end
        CS_RUN: begin
          if (susp_req)                 state_d = CS_IDLE;
          else if (wait_q != '0)        wait_d  = wait_q - 1'b1;
          else if (!ic_hit)             state_d = CS_IMISS;
          else if (dmiss)               state_d = CS_DMISS;
        end
        CS_IMISS:  if (miss_done) state_d = CS_IREADY;
        CS_IREADY: state_d = dmiss ? CS_DMISS : CS_RUN;
        CS_DMISS:  if (miss_done) state_d = CS_RUN;
        default:   state_d = CS_PARKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      err_q   <= !swout_req && (act_bad || susp_bad || done_bad);
    end
  end

  assign state = state_q;
  assign err   = err_q;

  // R5: no fetch outside Running
  a_r5_no_fetch_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CS_RUN) |-> !fetch_valid);
  // R6: the resume state always executes the held word
  a_r6_resume_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_IREADY && !swout_req) |-> (exec_valid && !fetch_valid));
  // R8: switched-out is terminal
  a_r8_parked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_PARKED) |=> (state_q == CS_PARKED));
  // R11: an illegal command in Idle leaves the state alone
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_IDLE && !act_req && !swout_req && (susp_req || miss_done))
    |=> (state_q == CS_IDLE && err_q));
endmodule

// File: rtl/corestep_pc.sv
module corestep_pc #(
  parameter int          PC_W     = 32,
  parameter int          INST_W   = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter bit          FULL_SYS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              trap_req,
  input  logic              hold_load,
  input  logic [INST_W-1:0] load_word,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   npc,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              fetch_phys,
  output logic [INST_W-1:0] held_word
);
  localparam logic [PC_W-1:0] STEP_BYTES = PC_W'(4);

  logic [PC_W-1:0]   pc_q, npc_q;
  logic [INST_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      npc_q  <= RESET_PC + STEP_BYTES;
      held_q <= '0;
    end else begin
      if (advance) begin
        pc_q  <= npc_q;
        npc_q <= npc_q + STEP_BYTES;
      end
      if (hold_load) held_q <= load_word;
    end
  end

  assign fetch_addr = {pc_q[PC_W-1:2], 2'b00};

  generate
    if (FULL_SYS) begin : g_phys
      assign fetch_phys = pc_q[0];
    end else begin : g_virt
      assign fetch_phys = 1'b0;
    end
  endgenerate

  assign pc        = pc_q;
  assign npc       = npc_q;
  assign held_word = held_q;

  // R9: a faulted step leaves the PC pair in place
  a_r9_trap_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ($stable(pc_q) && $stable(npc_q)));
endmodule

// File: rtl/corestep_stallctr.sv
module corestep_stallctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)               cnt_q <= '0;
    else if (inc && cnt_q != TOP)    cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R12: the counter sticks at its ceiling
  a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr) |=> (cnt_q == TOP));
  // R12: clear wins
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/corestep_top.sv
module corestep_top
  import corestep_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              INST_W   = 32,
  parameter int              DLY_W    = 4,
  parameter int              CNT_W    = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter bit              FULL_SYS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stats_clr,
  input  logic              act_req,
  input  logic [DLY_W-1:0]  act_dly,
  input  logic              susp_req,
  input  logic              swout_req,
  input  logic              miss_done,
  input  logic              ic_hit,
  input  logic [INST_W-1:0] ic_rdata,
  input  logic              ex_mem,
  input  logic              dc_hit,
  input  logic              ex_fault,
  output logic [2:0]        core_state,
  output logic              fetch_valid,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              fetch_phys,
  output logic              exec_valid,
  output logic [INST_W-1:0] exec_inst,
  output logic              trap_req,
  output logic              r0_clr,
  output logic              err,
  output logic [CNT_W-1:0]  ic_stall_cyc,
  output logic [CNT_W-1:0]  dc_stall_cyc,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   npc
);
  localparam int NUM_CTR = 2;

  core_state_e       state;
  logic              exec_held, hold_load, advance, step;
  logic [INST_W-1:0] held_word;
  logic [NUM_CTR-1:0] ctr_inc;
  logic [CNT_W-1:0]  ctr_val [NUM_CTR];

  corestep_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk, .rst_n, .act_req, .act_dly, .susp_req, .swout_req, .miss_done,
    .ic_hit, .ex_mem, .dc_hit, .ex_fault,
    .state, .fetch_valid, .exec_valid, .exec_held, .hold_load,
    .advance, .trap_req, .step, .err
  );

  corestep_pc #(
    .PC_W(PC_W), .INST_W(INST_W), .RESET_PC(RESET_PC), .FULL_SYS(FULL_SYS)
  ) u_pc (
    .clk, .rst_n, .advance, .trap_req, .hold_load,
    .load_word(ic_rdata), .pc, .npc, .fetch_addr, .fetch_phys, .held_word
  );

  assign ctr_inc[0] = (state == CS_IMISS);
  assign ctr_inc[1] = (state == CS_DMISS);

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      corestep_stallctr #(.CNT_W(CNT_W)) u_ctr (
        .clk, .rst_n, .clr(stats_clr), .inc(ctr_inc[g]), .count(ctr_val[g])
      );
    end
  endgenerate

  assign ic_stall_cyc = ctr_val[0];
  assign dc_stall_cyc = ctr_val[1];
  assign core_state   = state;
  assign exec_inst    = exec_held ? held_word : ic_rdata;
  assign r0_clr       = step;

  // R10: register-zero clear coincides with fetch or execute activity
  a_r10_r0_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    r0_clr |-> (fetch_valid || exec_valid));
endmodule

// File: tb/tb_corestep_top.sv
module tb_corestep_top;
  localparam int PC_W = 16;
  localparam int INST_W = 32;
  localparam int DLY_W = 3;
  localparam int CNT_W = 4;
  localparam logic [PC_W-1:0] RST_PC = 16'h0103;

  logic clk = 1'b0;
  logic rst_n, stats_clr, act_req, susp_req, swout_req, miss_done;
  logic ic_hit, ex_mem, dc_hit, ex_fault;
  logic [DLY_W-1:0] act_dly;
  logic [INST_W-1:0] ic_rdata, exec_inst;
  logic [2:0] core_state;
  logic fetch_valid, fetch_phys, exec_valid, trap_req, r0_clr, err;
  logic [PC_W-1:0] fetch_addr, pc, npc;
  logic [CNT_W-1:0] ic_stall_cyc, dc_stall_cyc;

  int n_chk = 0, n_bad = 0;
  logic [PC_W-1:0] exp_pc, exp_npc;
  int exp_ic, exp_dc;
  logic [CNT_W-1:0] c0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  corestep_top #(
    .PC_W(PC_W), .INST_W(INST_W), .DLY_W(DLY_W), .CNT_W(CNT_W),
    .RESET_PC(RST_PC), .FULL_SYS(1'b1)
  ) dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    stats_clr = 0; act_req = 0; susp_req = 0; swout_req = 0; miss_done = 0;
    ex_mem = 0; ex_fault = 0; ic_hit = 1; dc_hit = 1;
  endtask

  task automatic adv();
    exp_pc = exp_npc;
    exp_npc = exp_npc + 16'd4;
  endtask

  function automatic int sat(int v);
    return (v > 15) ? 15 : v;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; act_dly = 0; ic_rdata = 0;
    stats_clr = 0; act_req = 0; susp_req = 0; swout_req = 0; miss_done = 0;
    ex_mem = 0; ex_fault = 0; ic_hit = 1; dc_hit = 1;
    repeat (3) @(posedge clk);
    nxt(); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 state", core_state, 0);
    check("R1 pc", pc, RST_PC);
    check("R1 npc", npc, RST_PC + 16'd4);
    check("R1 ic cnt", ic_stall_cyc, 0);
    check("R1 dc cnt", dc_stall_cyc, 0);
    check("R1 strobes", {fetch_valid, exec_valid, trap_req, r0_clr, err}, 0);
    exp_pc = RST_PC; exp_npc = RST_PC + 16'd4;

    // R2/R3/R4/R10: sweep every activate delay
    for (int d = 0; d < 8; d++) begin
      nxt(); act_req = 1; act_dly = DLY_W'(d);
      #1 check("R2 no step in idle", fetch_valid, 0);
      nxt();
      check("R2 running", core_state, 1);
      for (int k = 0; k <= d; k++) begin
        if (k > 0) nxt();
        #1;
        check("R2 first step timing", fetch_valid, (k == d));
        check("R10 r0 clear", r0_clr, (k == d));
        if (k == d) begin
          check("R4 aligned addr", fetch_addr, {exp_pc[15:2], 2'b00});
          check("R4 phys flag", fetch_phys, exp_pc[0]);
          adv();
        end
      end
      nxt(); susp_req = 1;
      #1 check("R3 no step on suspend", fetch_valid, 0);
      check("R10 r0 idle on suspend", r0_clr, 0);
      nxt();
      check("R3 idle", core_state, 0);
      check("R9 pc", pc, exp_pc);
    end

    // R9: continuous stepping with one faulted step
    nxt(); act_req = 1; act_dly = 0;
    nxt();
    for (int i = 0; i < 12; i++) begin
      if (i > 0) nxt();
      if (i == 5) ex_fault = 1;
      #1;
      check("R4 fetch addr", fetch_addr, {exp_pc[15:2], 2'b00});
      check("R9 pc", pc, exp_pc);
      check("R9 npc", npc, exp_npc);
      check("R9 trap", trap_req, (i == 5));
      if (i != 5) adv();
    end
    nxt(); stats_clr = 1;
    #1 check("R9 pc after run", pc, exp_pc);
    adv();
    exp_ic = 0; exp_dc = 0;

    // R5/R6/R12: instruction-miss lengths 1..6, into saturation
    for (int L = 1; L <= 6; L++) begin
      nxt(); ic_hit = 0;
      #1 check("R5 fetch on miss", fetch_valid, 1);
      check("R5 no exec on miss", exec_valid, 0);
      check("R10 r0 on miss step", r0_clr, 1);
      nxt();
      check("R5 stall state", core_state, 2);
      check("R12 ic cnt", ic_stall_cyc, exp_ic);
      for (int j = 1; j <= L; j++) begin
        if (j > 1) nxt();
        if (j == L) begin miss_done = 1; ic_rdata = 32'hBEEF0000 + L; end
        #1 check("R5 no fetch in stall", fetch_valid, 0);
        exp_ic = sat(exp_ic + 1);
      end
      nxt(); ic_rdata = 32'h0;
      check("R6 resume state", core_state, 3);
      check("R12 ic cnt sat", ic_stall_cyc, exp_ic);
      #1;
      check("R6 exec held", exec_valid, 1);
      check("R6 no refetch", fetch_valid, 0);
      check("R6 held word", exec_inst, 32'hBEEF0000 + L);
      adv();
      nxt();
      check("R6 back to running", core_state, 1);
      check("R9 pc", pc, exp_pc);
      adv();
    end
    nxt(); stats_clr = 1; adv();
    nxt();
    check("R12 clear ic", ic_stall_cyc, 0);
    adv();
    exp_dc = 0;

    // R7: data-miss lengths 1..3
    for (int L = 1; L <= 3; L++) begin
      nxt(); ex_mem = 1; dc_hit = 0;
      #1 check("R7 exec on dmiss", exec_valid, 1);
      adv();
      nxt();
      check("R7 dstall state", core_state, 4);
      check("R7 pc advanced", pc, exp_pc);
      for (int j = 1; j <= L; j++) begin
        if (j > 1) nxt();
        if (j == L) miss_done = 1;
        #1 check("R7 no fetch in dstall", fetch_valid, 0);
        exp_dc++;
      end
      nxt();
      check("R7 running", core_state, 1);
      check("R12 dc cnt", dc_stall_cyc, exp_dc);
      #1 check("R7 immediate step", fetch_valid, 1);
      adv();
    end

    // R11: illegal commands
    nxt(); act_req = 1; act_dly = 5; adv();
    nxt();
    check("R11 err act in run", err, 1);
    check("R11 state kept", core_state, 1);
    adv();
    nxt();
    check("R11 err one cycle", err, 0);
    miss_done = 1; adv();
    nxt();
    check("R11 err done in run", err, 1);
    check("R11 state kept run", core_state, 1);
    susp_req = 1;
    nxt();
    check("R3 idle again", core_state, 0);
    check("R11 legal suspend no err", err, 0);
    susp_req = 1;
    nxt();
    check("R11 err suspend in idle", err, 1);
    check("R11 idle kept", core_state, 0);
    miss_done = 1;
    nxt();
    check("R11 err done in idle", err, 1);
    check("R11 idle kept 2", core_state, 0);
    nxt();
    check("R11 err clears", err, 0);

    // R8: switch-out during an instruction miss
    act_req = 1; act_dly = 0;
    nxt(); ic_hit = 0;
    nxt();
    check("R8 pre stall", core_state, 2);
    swout_req = 1;
    nxt();
    check("R8 parked", core_state, 5);
    c0 = ic_stall_cyc;
    miss_done = 1; ic_rdata = 32'h12345678;
    #1 check("R8 no step", {fetch_valid, exec_valid, r0_clr}, 0);
    nxt();
    check("R8 late done no err", err, 0);
    check("R8 still parked", core_state, 5);
    check("R8 cnt frozen", ic_stall_cyc, c0);
    act_req = 1;
    nxt();
    check("R8 activate ignored", core_state, 5);
    for (int i = 0; i < 3; i++) begin
      nxt();
      #1 check("R8 no exec", exec_valid, 0);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule